// File: doc/BRIEF.md
# Per-Source Interrupt Router with Software-Raised Sources

This block collects interrupt requests and steers each one to a chosen CPU interrupt line of a chosen thread. Two banks of sources exist. The lower bank holds hardware sources, whose pending state follows input wires. The upper bank starts at source index `N_HW` (64 by default) and holds software sources, which software raises and lowers through register writes. Each source has a private 64-bit routing word with three fields. An enable flag sits at bit 31, a thread number occupies bits 30:8, and a line number occupies bits 3:0. Every other bit of the routing word is fixed at zero.

Software reaches the block over a small 64-bit register port. Four windows are selected by a 2-bit code, listed here in address order:

| Code | Window | Purpose |
|------|--------|---------|
| 0 | routing | the per-source routing words |
| 1 | pending read | the pending bits |
| 2 | set | write-one-to-set of software pending bits |
| 3 | clear | write-one-to-clear of software pending bits |

Inside a window, `req_idx` is a 64-bit word index, so the byte offset is the index times 8. In the routing window the index is the source number. In the three pending windows, word `w` covers sources `64*w` to `64*w+63`. Source `n` sits at bit `n mod 64` of that word.

The port has no back-pressure. A request is taken in every cycle where `req_valid` is high. A read returns its data on `rd_data` with `rd_valid` high exactly one cycle later. For output line `k` of thread `t`, the output bit `irq_out[t*N_LINES+k]` is a level. It is the OR of every source that is enabled, pending, and routed to that line and thread.

Top module: `irq_router`

## Requirements
- R1: After reset every routing word reads zero, all software pending bits read zero, and `irq_out` is all zero.
- R2: A routing write keeps bit 31, bits 30:8 and bits 3:0. A read of that word returns those fields unchanged, with bits 63:32 and 7:4 reading zero.
- R3: The routing word of source `n` is reached at routing-window index `n`. A write to one source leaves the words of the other sources unchanged.
- R4: Hardware pending bits copy `irq_in` through one register stage. They appear in pending-read word 0, bit `n` for source `n`.
- R5: A write to the set window (code 2) at a software word sets exactly the pending bits whose mask bit is 1. A set or clear write to word 0 has no effect on the hardware pending bits.
- R6: A write to the clear window (code 3) at a software word clears exactly the pending bits whose mask bit is 1. The other pending bits keep their values.
- R7: Output bit `t*N_LINES+k` is high when, and only when, some source is enabled, pending, has line field `k` and has thread field `t`. A thread field of `N_THREADS` or more drives no output.
- R8: A line field of `N_LINES` (6) or more never drives any output, even when the source is enabled and pending.
- R9: A source whose enable bit is 0 never drives an output, whatever its other fields are.
- R10: A read request yields `rd_valid` high in the next cycle and only then. A read of pending-read word `w` returns the current pending bits of sources `64*w` to `64*w+63`.
- R11: A routing write at an index of `N_SRC` or above changes no state, and a routing read at such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N_HW | Hardware source request levels |
| req_valid | input | 1 | Register request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Window: 0 routing, 1 pending read, 2 set, 3 clear |
| req_idx | input | IDX_W | 64-bit word index within the window |
| req_wdata | input | 64 | Write data or bit mask |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Read data |
| irq_out | output | N_THREADS*N_LINES | Level interrupt lines, thread-major |

## Verification
The bound checker watches four things in every cycle:
- the read handshake timing;
- the zero reserved bits in routing reads;
- the one-stage copy of `irq_in` into pending word 0;
- the effect of every set and clear mask on the first software word.

Only the directed scenarios can show the routing itself: which output bit a given thread and line field lights. They also cover the silence of disabled sources, of out-of-range lines and of out-of-range threads, and the harmlessness of out-of-range routing indices. These checks need knowledge of the stored routing words, which the port alone does not reveal in a single cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int WORD_BITS = 64;
  localparam int TID_BITS  = 23;
  localparam int LINE_BITS = 4;
  localparam int EN_POS    = 31;
  localparam int TID_LSB   = 8;
  localparam int LINE_LSB  = 0;

  typedef enum logic [1:0] {
    WIN_CFG  = 2'd0,
    WIN_PEND = 2'd1,
    WIN_SET  = 2'd2,
    WIN_CLR  = 2'd3
  } win_e;

  typedef struct packed {
    logic                 en;
    logic [TID_BITS-1:0]  tid;
    logic [LINE_BITS-1:0] line;
  } route_t;

endpackage

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 128,
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [WORD_BITS-1:0] wdata,
  output route_t               route_q [N_SRC]
);
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(N_SRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SRC; i++) route_q[i] <= '0;
    end else if (wr_en && idx < LIMIT) begin
      route_q[idx[SRC_W-1:0]] <= '{en:   wdata[EN_POS],
                                   tid:  wdata[EN_POS-1:TID_LSB],
                                   line: wdata[LINE_LSB+LINE_BITS-1:LINE_LSB]};
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_router_pkg::*;
#(
  parameter int N_HW  = 64,
  parameter int N_SW  = 64,
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_HW-1:0]      irq_in,
  input  logic                 set_en,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [WORD_BITS-1:0] mask,
  output logic [N_HW-1:0]      hw_q,
  output logic [N_SW-1:0]      sw_q
);
  localparam int HW_WORDS = N_HW / WORD_BITS;
  localparam int SW_WORDS = N_SW / WORD_BITS;

  always_ff @(posedge clk) begin
    if (rst) hw_q <= '0;
    else     hw_q <= irq_in;
  end

  for (genvar w = 0; w < SW_WORDS; w++) begin : g_sw_word
    logic hit;
    assign hit = (idx == IDX_W'(HW_WORDS + w));
    always_ff @(posedge clk) begin
      if (rst) begin
        sw_q[w*WORD_BITS +: WORD_BITS] <= '0;
      end else if (hit && clr_en) begin
        sw_q[w*WORD_BITS +: WORD_BITS] <= sw_q[w*WORD_BITS +: WORD_BITS] & ~mask;
      end else if (hit && set_en) begin
        sw_q[w*WORD_BITS +: WORD_BITS] <= sw_q[w*WORD_BITS +: WORD_BITS] | mask;
      end
    end
  end
endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux
  import irq_router_pkg::*;
#(
  parameter int N_SRC     = 128,
  parameter int N_THREADS = 2,
  parameter int N_LINES   = 6
) (
  input  route_t             route_q [N_SRC],
  input  logic [N_SRC-1:0]   pend,
  output logic [N_THREADS*N_LINES-1:0] irq_out
);
  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    for (genvar k = 0; k < N_LINES; k++) begin : g_line
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < N_SRC; s++) begin
          hit = hit | (route_q[s].en && pend[s] &&
                       route_q[s].line == LINE_BITS'(k) &&
                       route_q[s].tid  == TID_BITS'(t));
        end
      end
      assign irq_out[t*N_LINES + k] = hit;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_HW      = 64,
  parameter int N_SW      = 64,
  parameter int N_THREADS = 2,
  parameter int N_LINES   = 6,
  parameter int IDX_W     = $clog2(N_HW + N_SW) + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_HW-1:0]              irq_in,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [1:0]                   req_win,
  input  logic [IDX_W-1:0]             req_idx,
  input  logic [63:0]                  req_wdata,
  output logic                         rd_valid,
  output logic [63:0]                  rd_data,
  output logic [N_THREADS*N_LINES-1:0] irq_out
);
  localparam int N_SRC   = N_HW + N_SW;
  localparam int N_WORDS = N_SRC / WORD_BITS;
  localparam int SRC_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(N_SRC);

  route_t             route_q [N_SRC];
  logic [N_HW-1:0]    hw_q;
  logic [N_SW-1:0]    sw_q;
  logic [N_SRC-1:0]   pend_all;
  logic               wr_cfg, wr_set, wr_clr, rd_req;
  logic [63:0]        rd_next;

  assign wr_cfg   = req_valid && req_write && (req_win == WIN_CFG);
  assign wr_set   = req_valid && req_write && (req_win == WIN_SET);
  assign wr_clr   = req_valid && req_write && (req_win == WIN_CLR);
  assign rd_req   = req_valid && !req_write;
  assign pend_all = {sw_q, hw_q};

  irq_route_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_route (
    .clk(clk), .rst(rst), .wr_en(wr_cfg), .idx(req_idx),
    .wdata(req_wdata), .route_q(route_q)
  );

  irq_pend_bank #(.N_HW(N_HW), .N_SW(N_SW), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .set_en(wr_set), .clr_en(wr_clr),
    .idx(req_idx), .mask(req_wdata), .hw_q(hw_q), .sw_q(sw_q)
  );

  irq_line_mux #(.N_SRC(N_SRC), .N_THREADS(N_THREADS), .N_LINES(N_LINES)) u_mux (
    .route_q(route_q), .pend(pend_all), .irq_out(irq_out)
  );

  always_comb begin
    rd_next = '0;
    unique case (req_win)
      WIN_CFG: begin
        if (req_idx < LIMIT) begin
          rd_next[EN_POS]                 = route_q[req_idx[SRC_W-1:0]].en;
          rd_next[EN_POS-1:TID_LSB]       = route_q[req_idx[SRC_W-1:0]].tid;
          rd_next[LINE_BITS-1:LINE_LSB]   = route_q[req_idx[SRC_W-1:0]].line;
        end
      end
      WIN_PEND: begin
        for (int w = 0; w < N_WORDS; w++) begin
          if (req_idx == IDX_W'(w)) rd_next = pend_all[w*WORD_BITS +: WORD_BITS];
        end
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int N_HW  = 64,
  parameter int N_SW  = 64,
  parameter int IDX_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_HW-1:0]   irq_in,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_win,
  input logic [IDX_W-1:0]  req_idx,
  input logic [63:0]       req_wdata,
  input logic              rd_valid,
  input logic [63:0]       rd_data,
  input logic [N_SW-1:0]   sw_q
);
  localparam logic [IDX_W-1:0] SW0 = IDX_W'(N_HW / 64);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r10_read_valid: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_win == WIN_CFG) |=>
      (rd_data[63:32] == 32'h0 && rd_data[7:4] == 4'h0));

  a_r4_hw_follows_input: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && req_valid && !req_write && req_win == WIN_PEND &&
     req_idx == '0) |=> (rd_data == $past(irq_in[63:0], 2)));

  a_r5_set_mask: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_win == WIN_SET && req_idx == SW0) |=>
      ((sw_q[63:0] & $past(req_wdata)) == $past(req_wdata)));

  a_r6_clear_mask: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_win == WIN_CLR && req_idx == SW0) |=>
      ((sw_q[63:0] & $past(req_wdata)) == 64'h0));

  a_r6_clear_keeps_rest: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_win == WIN_CLR && req_idx == SW0) |=>
      ((sw_q[63:0] & ~$past(req_wdata)) == ($past(sw_q[63:0]) & ~$past(req_wdata))));
endmodule

bind irq_router irq_router_chk #(.N_HW(N_HW), .N_SW(N_SW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .req_valid(req_valid),
  .req_write(req_write), .req_win(req_win), .req_idx(req_idx),
  .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .sw_q(sw_q)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int IDX_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_win = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [11:0] irq_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .req_valid(req_valid),
    .req_write(req_write), .req_win(req_win), .req_idx(req_idx),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] win, input int idx, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_win = win;
    req_idx = IDX_W'(idx); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] win, input int idx, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_win = win; req_idx = IDX_W'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 rd_valid", {63'b0, rd_valid}, 64'd1);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 outputs after reset", {52'b0, irq_out}, 64'h0);
    rd(2'd0, 0, d);   chk("R1 routing word 0", d, 64'h0);
    rd(2'd0, 127, d); chk("R1 routing word 127", d, 64'h0);
    rd(2'd1, 1, d);   chk("R1 software pending", d, 64'h0);
    @(negedge clk);
    chk("R10 no valid without read", {63'b0, rd_valid}, 64'h0);
  endtask

  task automatic t_fields();
    logic [63:0] d;
    wr(2'd0, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, 3, d); chk("R2 field mask", d, 64'h0000_0000_FFFF_FF0F);
    rd(2'd0, 4, d); chk("R3 neighbour untouched", d, 64'h0);
    wr(2'd0, 3, 64'h0);
    rd(2'd0, 3, d); chk("R3 rewrite to zero", d, 64'h0);
  endtask

  task automatic t_hw_route();
    logic [63:0] d;
    wr(2'd0, 5, 64'h8000_0102);          // enable, thread 1, line 2
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk);
    chk("R7 hw source thread1 line2", {52'b0, irq_out}, 64'h100);
    rd(2'd1, 0, d); chk("R4 hw pending word 0", d, 64'h20);
    wr(2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, 0, d); chk("R5 clear on word 0 ignored", d, 64'h20);
    irq_in[5] = 1'b0;
    @(negedge clk);
    chk("R4 hw drop follows input", {52'b0, irq_out}, 64'h0);
    wr(2'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, 0, d); chk("R5 set on word 0 ignored", d, 64'h0);
  endtask

  task automatic t_sw_set_clear();
    logic [63:0] d;
    wr(2'd0, 70, 64'h8000_0005);         // source 70: thread 0 line 5
    wr(2'd2, 1, 64'h40);
    chk("R7 sw source thread0 line5", {52'b0, irq_out}, 64'h20);
    rd(2'd1, 1, d); chk("R10 sw pending word", d, 64'h40);
    wr(2'd2, 1, 64'h8000_0000_0000_0001);
    rd(2'd1, 1, d); chk("R5 set accumulates", d, 64'h8000_0000_0000_0041);
    wr(2'd3, 1, 64'h40);
    chk("R6 cleared source drops", {52'b0, irq_out}, 64'h0);
    rd(2'd1, 1, d); chk("R6 other bits kept", d, 64'h8000_0000_0000_0001);
    wr(2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd1, 1, d); chk("R6 clear all", d, 64'h0);
  endtask

  task automatic t_silent();
    logic [63:0] d;
    wr(2'd0, 71, 64'h8000_0007);         // line 7
    wr(2'd0, 72, 64'h0000_0000);         // disabled, thread 0 line 0
    wr(2'd0, 73, 64'h8000_0500);         // thread 5, line 0
    wr(2'd2, 1, 64'h380);
    chk("R8 R9 R7 silent sources", {52'b0, irq_out}, 64'h0);
    rd(2'd1, 1, d); chk("R8 pending still visible", d, 64'h380);
    wr(2'd0, 72, 64'h8000_0000);
    chk("R9 enabling lights thread0 line0", {52'b0, irq_out}, 64'h1);
    wr(2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_out_of_range();
    logic [63:0] d;
    wr(2'd0, 200, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd0, 200, d); chk("R11 out-of-range read zero", d, 64'h0);
    rd(2'd0, 72, d);  chk("R11 no alias into source 72", d, 64'h8000_0000);
    rd(2'd0, 0, d);   chk("R11 no alias into source 0", d, 64'h0);
    chk("R11 outputs unchanged", {52'b0, irq_out}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_hw_route();
    t_sw_set_clear();
    t_silent();
    t_out_of_range();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule